// File: doc/BRIEF.md
# Command-Stepped I2C Bus Master

This block is an I2C master in which software drives every bus phase with its own command. A host places an operation code in a 3-bit mode field and pulses a trigger. Four operations exist: open the bus with a start condition, shift one byte out, shift one byte in, or close the bus with a stop condition. Each operation runs to completion. The block then raises an interrupt flag and reports a 3-bit completion code that names the event.

Both bus lines are open-drain. The block only ever pulls a line low, and it reads the SDA level back from the pin. Bit timing comes from a quarter-bit divider, so each bit takes four quarters. Slave addressing is left to software. A 7-bit address goes out as one byte, with the address in bits 7..1 and the direction in bit 0 (0 = write to slave, 1 = read from slave). A 10-bit address goes out as a header byte `11110,A9,A8,R/W` followed by A7..A0. A 10-bit read then issues a repeated start and a header with R/W = 1.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, busy, interrupt flag, status code and bus-held are all 0 and neither line is pulled low; while the bus is free and no command runs, both lines stay released.
- R2: A trigger is accepted only when no command is running. Mode codes: 0 = start, 1 = transmit byte, 2 = receive byte, 3 = stop. Codes 4 to 7 are ignored. An accepted trigger raises busy on the next cycle.
- R3: While the bus is not held, a trigger with any mode other than 0 is ignored and busy stays 0.
- R4: A start pulls SDA low while SCL is high. Busy lasts 4*DIV cycles. On completion the status is 0x0, the interrupt flag is set and bus-held becomes 1.
- R5: A transmit shifts the latched byte MSB first over 8 SCL pulses, then releases SDA for a ninth acknowledge pulse. The status is 0x5 if SDA was low in that slot and 0x6 if it was high. Busy lasts 36*DIV cycles.
- R6: A receive samples 8 bits MSB first into the receive byte. In the ninth slot it drives the ack level latched at the trigger (0 pulls SDA low). The status is 0x2 and busy lasts 36*DIV cycles.
- R7: During byte commands the block changes its SDA drive only while SCL is low.
- R8: A stop releases SDA while SCL is high. Busy lasts 4*DIV cycles, the status is 0x7, and bus-held drops to 0.
- R9: A clear pulse resets both the interrupt flag and the status code to 0. If a completion lands in the same cycle, the completion wins.
- R10: A trigger issued while busy has no effect: the running command keeps its length and outcome.
- R11: A start while the bus is held produces a repeated start condition, as used by 10-bit reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Operation code for the next trigger |
| trig_i | input | 1 | One-cycle command launch pulse |
| txd_i | input | 8 | Byte to transmit, latched at trigger |
| ack_lvl_i | input | 1 | Level driven in the receive ack slot (0 = acknowledge) |
| irq_clr_i | input | 1 | Clears the interrupt flag and the status code |
| sda_i | input | 1 | SDA level read back from the pin |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | A command is running |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 3 | Completion code of the last command |
| rxd_o | output | 8 | Last received byte |
| bus_held_o | output | 1 | Bus is occupied between start and stop |

## Verification
An accepted trigger raises busy on the edge where the trigger is sampled. Busy then stays high for exactly 4*DIV cycles for start and stop, and 36*DIV cycles for a byte. The status, interrupt flag, received byte and bus-held change on the same edge that drops busy.

The bench counts busy cycles at falling clock edges, beginning one edge after the trigger. It reads the results only once busy has dropped. Bit values are taken at SCL rising edges, and the slave model changes SDA only on SCL falling edges. Start and stop conditions are counted as SDA edges while SCL is high, and those counts must equal the commands issued.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_START, ENG_XFER, ENG_STOP} eng_state_e;

  localparam logic [2:0] MODE_START = 3'd0;
  localparam logic [2:0] MODE_SEND  = 3'd1;
  localparam logic [2:0] MODE_RECV  = 3'd2;
  localparam logic [2:0] MODE_STOP  = 3'd3;

  localparam logic [2:0] CODE_START = 3'd0;
  localparam logic [2:0] CODE_RXEND = 3'd2;
  localparam logic [2:0] CODE_ACK   = 3'd5;
  localparam logic [2:0] CODE_NACK  = 3'd6;
  localparam logic [2:0] CODE_STOP  = 3'd7;

  localparam int unsigned BYTE_SLOTS = 9;  // 8 data + 1 acknowledge

  // completion code of a transmit, from the level seen in the ack slot
  function automatic logic [2:0] send_code(input logic ack_line);
    return ack_line ? CODE_NACK : CODE_ACK;
  endfunction

  // bit sent in slot idx (0 = first on the wire = MSB)
  function automatic logic bit_level(input logic [7:0] data, input logic [2:0] idx);
    return data[3'd7 - idx];
  endfunction
endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_go,
  input  logic [2:0] cmd_mode,
  input  logic [7:0] cmd_data,
  input  logic       ack_lvl,
  input  logic       sda_in,
  output eng_state_e state,
  output logic       held,
  output logic       scl_low,
  output logic       sda_low,
  output logic       done,
  output logic [2:0] done_code,
  output logic [7:0] rx_byte
);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_SLOTS - 1);

  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] shreg;
  logic       is_rx;
  logic       ackv;
  logic       ack_seen;

  // last quarter of the final slot of any command
  assign done = tick && (q == 2'd3) && (state != ENG_IDLE) &&
                ((state != ENG_XFER) || (bitn == ACK_SLOT));

  always_comb begin
    unique case (state)
      ENG_START: done_code = CODE_START;
      ENG_STOP:  done_code = CODE_STOP;
      ENG_XFER:  done_code = is_rx ? CODE_RXEND : send_code(ack_seen);
      default:   done_code = CODE_START;
    endcase
  end

  // line drive decode, per command and quarter
  always_comb begin
    scl_low = held;
    sda_low = 1'b0;
    unique case (state)
      ENG_START: begin
        scl_low = (q == 2'd0) ? held : (q == 2'd3);
        sda_low = q[1];
      end
      ENG_STOP: begin
        scl_low = (q == 2'd0);
        sda_low = !q[1];
      end
      ENG_XFER: begin
        scl_low = (q == 2'd0) || (q == 2'd3);
        if (is_rx) sda_low = (bitn == ACK_SLOT) && !ackv;
        else       sda_low = (bitn != ACK_SLOT) && !bit_level(shreg, bitn[2:0]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      held     <= 1'b0;
      q        <= '0;
      bitn     <= '0;
      shreg    <= '0;
      is_rx    <= 1'b0;
      ackv     <= 1'b1;
      ack_seen <= 1'b1;
      rx_byte  <= '0;
    end else if (state == ENG_IDLE) begin
      if (cmd_go) begin
        q     <= '0;
        bitn  <= '0;
        shreg <= cmd_data;
        is_rx <= (cmd_mode == MODE_RECV);
        ackv  <= ack_lvl;
        unique case (cmd_mode)
          MODE_START:           state <= ENG_START;
          MODE_SEND, MODE_RECV: state <= ENG_XFER;
          default:              state <= ENG_STOP;
        endcase
      end
    end else if (tick) begin
      q <= q + 2'd1;
      if (state == ENG_XFER && q == 2'd2) begin
        if (bitn == ACK_SLOT) ack_seen <= sda_in;
        else if (is_rx)       shreg    <= {shreg[6:0], sda_in};
      end
      if (q == 2'd3) begin
        if (state == ENG_XFER && bitn != ACK_SLOT) begin
          bitn <= bitn + 4'd1;
        end else begin
          held  <= (state != ENG_STOP);
          if (state == ENG_XFER && is_rx) rx_byte <= shreg;
          state <= ENG_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_status.sv
module i2c_cmd_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  logic [2:0] code,
  input  logic       clr,
  output logic       irq,
  output logic [2:0] status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      status <= '0;
    end else if (done) begin
      irq    <= 1'b1;
      status <= code;
    end else if (clr) begin
      irq    <= 1'b0;
      status <= '0;
    end
  end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       trig_i,
  input  logic [7:0] txd_i,
  input  logic       ack_lvl_i,
  input  logic       irq_clr_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       irq_o,
  output logic [2:0] status_o,
  output logic [7:0] rxd_o,
  output logic       bus_held_o
);
  eng_state_e state;
  logic       held;
  logic       tick_w;
  logic       mode_ok_w;
  logic       accept_w;
  logic       done_w;
  logic [2:0] done_code_w;
  logic       xfer_w;
  logic       stop_done_w;

  assign busy_o      = (state != ENG_IDLE);
  assign bus_held_o  = held;
  assign xfer_w      = (state == ENG_XFER);
  assign stop_done_w = done_w && (state == ENG_STOP);
  assign mode_ok_w   = (mode_i == MODE_START) ||
                       (held && (mode_i == MODE_SEND || mode_i == MODE_RECV ||
                                 mode_i == MODE_STOP));
  assign accept_w    = trig_i && !busy_o && mode_ok_w;

  i2c_quarter_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy_o), .tick(tick_w)
  );

  i2c_cmd_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick_w),
    .cmd_go(accept_w), .cmd_mode(mode_i), .cmd_data(txd_i), .ack_lvl(ack_lvl_i),
    .sda_in(sda_i), .state(state), .held(held),
    .scl_low(scl_oe_o), .sda_low(sda_oe_o),
    .done(done_w), .done_code(done_code_w), .rx_byte(rxd_o)
  );

  i2c_cmd_status u_stat (
    .clk(clk), .rst_n(rst_n), .done(done_w), .code(done_code_w),
    .clr(irq_clr_i), .irq(irq_o), .status(status_o)
  );
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       trig_i,
  input logic       irq_clr_i,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       busy_o,
  input logic       irq_o,
  input logic [2:0] status_o,
  input logic       bus_held_o,
  input logic       accept_w,
  input logic       done_w,
  input logic [2:0] done_code_w,
  input logic       xfer_w,
  input logic       stop_done_w
);
  p_free_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !bus_held_o) |-> (!scl_oe_o && !sda_oe_o));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> busy_o);

  p_ignore_unheld_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !bus_held_o && trig_i && mode_i != 3'd0) |=> !busy_o);

  p_sda_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_w && !scl_oe_o && $past(!scl_oe_o)) |-> $stable(sda_oe_o));

  p_stop_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done_w |=> !bus_held_o);

  p_done_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> (irq_o && status_o == $past(done_code_w)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_i && !done_w) |=> (!irq_o && status_o == 3'd0));

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_w) |=> busy_o);
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .trig_i(trig_i), .irq_clr_i(irq_clr_i),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o), .irq_o(irq_o),
  .status_o(status_o), .bus_held_o(bus_held_o), .accept_w(accept_w), .done_w(done_w),
  .done_code_w(done_code_w), .xfer_w(xfer_w), .stop_done_w(stop_done_w)
);

// File: tb/i2c_cmd_master_tb_top.sv
module i2c_cmd_master_tb_top;
  localparam int unsigned DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = '0;
  logic       trig_i = 1'b0;
  logic [7:0] txd_i = '0;
  logic       ack_lvl_i = 1'b0;
  logic       irq_clr_i = 1'b0;
  logic       slave_pull = 1'b0;
  logic       scl_oe_o, sda_oe_o, busy_o, irq_o, bus_held_o;
  logic [2:0] status_o;
  logic [7:0] rxd_o;
  wire        scl_line = !scl_oe_o;
  wire        sda_line = !(sda_oe_o || slave_pull);

  int total = 0;
  int fails = 0;
  int starts = 0;
  int stops = 0;

  i2c_cmd_master #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .trig_i(trig_i), .txd_i(txd_i),
    .ack_lvl_i(ack_lvl_i), .irq_clr_i(irq_clr_i), .sda_i(sda_line),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o), .irq_o(irq_o),
    .status_o(status_o), .rxd_o(rxd_o), .bus_held_o(bus_held_o)
  );

  always #10 clk = !clk;

  always @(negedge sda_line) if (rst_n && scl_line) starts++;
  always @(posedge sda_line) if (rst_n && scl_line) stops++;

  function automatic int short_len(); return 4 * DIV; endfunction
  function automatic int byte_len();  return 9 * 4 * DIV; endfunction
  function automatic int tx_code(input logic ack_line); return ack_line ? 6 : 5; endfunction
  function automatic logic [7:0] hdr10(input logic [9:0] a, input logic rd);
    return {5'b11110, a[9:8], rd};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    total++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  // pulse a trigger; returns one falling edge after the edge that samples it
  task automatic fire(input logic [2:0] m, input logic [7:0] d, input logic a);
    @(negedge clk);
    mode_i = m; txd_i = d; ack_lvl_i = a; trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr_i = 1'b1;
    @(negedge clk); irq_clr_i = 1'b0;
    check(irq_o == 1'b0 && status_o == 3'd0, "R9 clear", {irq_o, status_o}, 0);
  endtask

  task automatic do_start();
    int n; int s0;
    s0 = starts;
    fire(3'd0, 8'h00, 1'b0);
    count_busy(n);
    check(n == short_len(), "R4 start length", n, short_len());
    check(status_o == 3'd0 && irq_o && bus_held_o, "R4 start result",
          {irq_o, bus_held_o, status_o}, 5'b11000);
    check(starts == s0 + 1, "R4 R11 start condition", starts, s0 + 1);
    clear_irq();
  endtask

  task automatic do_tx(input logic [7:0] b, input logic ack_line);
    int n; logic [7:0] got; logic ackseen;
    got = '0; ackseen = 1'b0; n = 0;
    fire(3'd1, b, 1'b0);
    fork
      count_busy(n);
      begin
        for (int i = 0; i < 8; i++) begin
          @(posedge scl_line); got[7-i] = sda_line;
        end
        @(negedge scl_line); slave_pull = !ack_line;
        @(posedge scl_line); ackseen = sda_line;
        @(negedge scl_line); slave_pull = 1'b0;
      end
    join
    check(got == b, "R5 bits on wire", got, b);
    check(ackseen == ack_line, "R5 ack slot released", ackseen, ack_line);
    check(n == byte_len(), "R5 byte length", n, byte_len());
    check(status_o == 3'(tx_code(ack_line)) && irq_o, "R5 status", status_o, tx_code(ack_line));
    check(bus_held_o, "R5 bus still held", bus_held_o, 1);
  endtask

  task automatic do_rx(input logic [7:0] b, input logic mack);
    int n; logic got_ack;
    got_ack = 1'b0; n = 0;
    slave_pull = !b[7];
    fire(3'd2, 8'h00, mack);
    fork
      count_busy(n);
      begin
        for (int i = 0; i < 8; i++) begin
          @(posedge scl_line); @(negedge scl_line);
          slave_pull = (i < 7) ? !b[6-i] : 1'b0;
        end
        @(posedge scl_line); got_ack = sda_line;
      end
    join
    check(rxd_o == b, "R6 received byte", rxd_o, b);
    check(got_ack == mack, "R6 ack level driven", got_ack, mack);
    check(n == byte_len(), "R6 byte length", n, byte_len());
    check(status_o == 3'd2 && irq_o, "R6 status", status_o, 2);
  endtask

  task automatic do_stop();
    int n; int p0;
    p0 = stops;
    fire(3'd3, 8'h00, 1'b0);
    count_busy(n);
    check(n == short_len(), "R8 stop length", n, short_len());
    check(status_o == 3'd7 && irq_o && !bus_held_o, "R8 stop result",
          {irq_o, bus_held_o, status_o}, 5'b10111);
    check(stops == p0 + 1, "R8 stop condition", stops, p0 + 1);
    check(!scl_oe_o && !sda_oe_o, "R1 lines released after stop", {scl_oe_o, sda_oe_o}, 0);
  endtask

  initial begin
    int n; int s0; logic [7:0] st;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!busy_o && !irq_o && status_o == 3'd0 && !bus_held_o && !scl_oe_o && !sda_oe_o,
          "R1 reset state", {busy_o, irq_o, bus_held_o, status_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: byte/stop commands on a free bus do nothing
    fire(3'd1, 8'hA5, 1'b0);
    check(!busy_o, "R3 transmit before start", busy_o, 0);
    fire(3'd3, 8'h00, 1'b0);
    repeat (2) @(negedge clk);
    check(!busy_o && !irq_o && !bus_held_o, "R3 stop before start", {busy_o, irq_o, bus_held_o}, 0);

    // R10: trigger during a running start
    s0 = starts;
    fire(3'd0, 8'h00, 1'b0);
    @(negedge clk); mode_i = 3'd3; trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    count_busy(n);
    check(n + 2 == short_len(), "R10 length unchanged", n + 2, short_len());
    check(bus_held_o && status_o == 3'd0, "R10 outcome unchanged", {bus_held_o, status_o}, 8);
    check(starts == s0 + 1, "R4 start condition", starts, s0 + 1);
    clear_irq();

    // R2: reserved mode codes ignored while held
    st = {5'd0, status_o};
    for (int m = 4; m < 8; m++) begin
      fire(3'(m), 8'h00, 1'b0);
      check(!busy_o && !irq_o, "R2 reserved mode ignored", busy_o, 0);
    end
    check(status_o == st[2:0], "R2 status untouched", status_o, st[2:0]);

    // 7-bit write, directed ack/nack corners
    do_tx({7'h50, 1'b0}, 1'b0);
    do_tx(8'hFF, 1'b1);
    do_tx(8'h00, 1'b0);
    do_stop();

    // 10-bit read sequence with repeated start (R11)
    do_start();
    do_tx(hdr10(10'h2C7, 1'b0), 1'b0);
    do_tx(8'hC7, 1'b0);
    do_start();
    do_tx(hdr10(10'h2C7, 1'b1), 1'b0);
    do_rx(8'h00, 1'b0);
    do_rx(8'hFF, 1'b1);
    do_stop();

    // constrained random traffic
    do_start();
    for (int k = 0; k < 24; k++) begin
      logic [7:0] b; logic f;
      b = 8'($urandom);
      f = 1'($urandom);
      if ($urandom % 2 == 0) do_tx(b, f);
      else                   do_rx(b, f);
      if ($urandom % 4 == 0) clear_irq();
    end
    do_stop();

    check(starts == 4 && stops == 3, "R7 no stray line events", starts * 10 + stops, 43);
    summary();
  end
endmodule